// File: doc/BRIEF.md
# Cascaded Backplane Phase Synchronizer

This block keeps the backplane phase counter of one LCD driver aligned with the counters of other drivers that sit on the same display. All drivers share one active-low, wired-AND line. Each instance moves its backplane index forward on a frame-rate tick. The number of phases in a cycle follows the selected multiplex mode. When an instance reaches its last active phase, it pulls the shared line low through an open-drain output enable. In every other phase it watches the line.

The line is brought in through a synchronizer. The instance masks its own pull-down, delayed by the same amount as the synchronizer. When some other device pulls the line low while this instance is not yet in its last phase, the counter jumps straight to the last phase. The device that asserts first therefore pulls every lagging device into step, and all of them wrap to phase 0 together on the next tick. After reset every instance starts at phase 0, so devices released from a common reset begin in step.

Top module: `bp_phase_sync`

## Requirements
- R1: While reset is high and on the first cycle after it, `bp_index` is 0 and `sync_drive_en` is 0.
- R2: `mux_mode` value m (0 = static, 1 = two phases, 2 = three, 3 = four) gives m+1 phases. Each `frame_tick` moves `bp_index` one step through 0..m and back to 0. Without a tick or a realignment, `bp_index` holds.
- R3: From the second cycle after reset, and while `mux_mode` is steady, `sync_drive_en` is 1 exactly when `bp_index` equals m. In static mode it is therefore always 1.
- R4: A low level on `sync_in` that this instance did not cause, seen while `bp_index` is not m, forces `bp_index` to m. The change appears on the third rising clock edge after the line goes low, and `sync_drive_en` rises together with it.
- R5: A low level on `sync_in` while `bp_index` already equals m leaves the index at m. The next tick wraps it to 0.
- R6: A low level on `sync_in` caused only by this instance's own `sync_drive_en`, including the part that lingers in the synchronizer after the drive is released, never realigns the counter.
- R7: When a realignment and a tick take effect on the same edge, the realignment wins and `bp_index` becomes m.
- R8: If a mode change leaves `bp_index` above the new m, the next tick returns it to 0, and `sync_drive_en` stays 0 until the index equals m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse that advances the backplane phase |
| mux_mode | input | 2 | Multiplex mode m; the cycle has m+1 phases |
| sync_in | input | 1 | Level sampled from the shared line, low = asserted |
| bp_index | output | 2 | Current backplane phase index |
| sync_drive_en | output | 1 | Open-drain pull-down enable for the shared line |

## Verification
The bench builds the block with its default configuration: a 2-bit phase index and a two-stage synchronizer. This makes every mode and every starting phase few enough to sweep completely. The bench drives the shared line as the wired-AND of the instance's own drive and a pull-down that stands for the other devices. This exposes the synchronizer's lingering low level after a release, the three-edge realignment latency, a realignment that coincides with a tick, and a mode reduction that leaves the index out of range.

// File: rtl/bp_sync_pkg.sv
package bp_sync_pkg;
  // Largest number of backplane phases in any multiplex mode.
  localparam int unsigned MAX_PHASES = 4;
  localparam int unsigned PHASE_W    = $clog2(MAX_PHASES);

  typedef logic [PHASE_W-1:0] phase_t;

  // Mode value m selects m+1 phases, so the final phase index equals m.
  function automatic phase_t final_phase(input phase_t mode);
    return mode;
  endfunction
endpackage

// File: rtl/bp_sync_cdc.sv
// Shift-register synchronizer with a selectable idle (reset) level.
module bp_sync_cdc #(
  parameter int unsigned STAGES = 2,
  parameter bit          IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{IDLE}};
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/bp_phase_ctr.sv
// Backplane phase counter with forced realignment to the final phase.
module bp_phase_ctr #(
  parameter int unsigned PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [PHASE_W-1:0] last_ph,
  input  logic               line_act,
  input  logic               own_mask,
  output logic [PHASE_W-1:0] phase_q,
  output logic               drive_q,
  output logic               resync_hit
);
  logic [PHASE_W-1:0] phase_nx;
  logic               at_or_past_end;

  always_comb begin
    resync_hit     = line_act && !own_mask && (phase_q != last_ph);
    at_or_past_end = (phase_q >= last_ph);
    if (resync_hit) begin
      phase_nx = last_ph;
    end else if (tick) begin
      phase_nx = at_or_past_end ? '0 : PHASE_W'(phase_q + 1'b1);
    end else begin
      phase_nx = phase_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      drive_q <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      drive_q <= (phase_nx == last_ph);
    end
  end
endmodule

// File: rtl/bp_phase_sync.sv
// Top: cascaded backplane phase synchronizer for one driver instance.
module bp_phase_sync #(
  parameter int unsigned PHASE_W     = bp_sync_pkg::PHASE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_tick,
  input  logic [PHASE_W-1:0] mux_mode,
  input  logic               sync_in,
  output logic [PHASE_W-1:0] bp_index,
  output logic               sync_drive_en
);
  logic               line_s;
  logic               own_s;
  logic               line_act;
  logic               resync_hit;
  logic [PHASE_W-1:0] last_ph;

  assign last_ph = PHASE_W'(mux_mode);

  // Shared line enters through the synchronizer; idle level is high.
  bp_sync_cdc #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) line_sync_i (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (line_s)
  );

  // Own drive delayed by the same depth so its echo can be masked.
  bp_sync_cdc #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) own_dly_i (
    .clk (clk),
    .rst (rst),
    .d   (sync_drive_en),
    .q   (own_s)
  );

  assign line_act = ~line_s;

  bp_phase_ctr #(.PHASE_W(PHASE_W)) ctr_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (frame_tick),
    .last_ph    (last_ph),
    .line_act   (line_act),
    .own_mask   (own_s),
    .phase_q    (bp_index),
    .drive_q    (sync_drive_en),
    .resync_hit (resync_hit)
  );
endmodule

// File: rtl/bp_phase_sync_chk.sv
module bp_phase_sync_chk #(
  parameter int unsigned PHASE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_tick,
  input logic [PHASE_W-1:0] mux_mode,
  input logic [PHASE_W-1:0] bp_index,
  input logic               sync_drive_en,
  input logic               resync_hit
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (bp_index == '0 && !sync_drive_en));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!frame_tick && !resync_hit) |=> $stable(bp_index));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !resync_hit && bp_index < mux_mode)
    |=> bp_index == PHASE_W'($past(bp_index) + 1'b1));

  a_r3_drive_last: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $stable(mux_mode)) |-> (sync_drive_en == (bp_index == mux_mode)));

  a_r4_force_last: assert property (@(posedge clk) disable iff (rst)
    resync_hit |=> (bp_index == $past(mux_mode) && sync_drive_en));

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (bp_index == mux_mode && frame_tick) |=> bp_index == '0);

  a_r8_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (bp_index > mux_mode && frame_tick && !resync_hit) |=> bp_index == '0);
endmodule

bind bp_phase_sync bp_phase_sync_chk #(.PHASE_W(PHASE_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .frame_tick    (frame_tick),
  .mux_mode      (mux_mode),
  .bp_index      (bp_index),
  .sync_drive_en (sync_drive_en),
  .resync_hit    (resync_hit)
);

// File: tb/bp_phase_sync_tb_top.sv
module bp_phase_sync_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic [1:0] mux_mode = 2'd0;
  logic       ext_low = 1'b0;
  logic       sync_line;
  logic [1:0] bp_index;
  logic       sync_drive_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // Wired-AND shared line: low when this device or any other pulls it.
  assign sync_line = ~(sync_drive_en | ext_low);

  bp_phase_sync dut_i (
    .clk           (clk),
    .rst           (rst),
    .frame_tick    (frame_tick),
    .mux_mode      (mux_mode),
    .sync_in       (sync_line),
    .bp_index      (bp_index),
    .sync_drive_en (sync_drive_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic restart(input int m);
    @(negedge clk) rst = 1'b1;
    mux_mode = 2'(m);
    ext_low  = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(2);
  endtask

  initial begin
    // R1: reset state
    idle(3);
    check("R1 index in reset", int'(bp_index), 0);
    check("R1 drive in reset", int'(sync_drive_en), 0);
    @(negedge clk) rst = 1'b0;
    mux_mode = 2'd3;
    @(negedge clk);
    check("R1 index first cycle", int'(bp_index), 0);

    // R2, R3, R6: sweep every mode; own pull-down echoes must not realign
    for (int m = 0; m < 4; m++) begin
      restart(m);
      for (int k = 0; k < 10; k++) begin
        check("R2 index sequence", int'(bp_index), k % (m + 1));
        check("R3 drive on last", int'(sync_drive_en), int'((k % (m + 1)) == m));
        do_tick();
        idle(4);
      end
      idle(6);
      check("R6 no self realign", int'(bp_index), 10 % (m + 1));
    end

    // R4: realignment from each non-final phase, with latency
    for (int m = 1; m < 4; m++) begin
      for (int p = 0; p < m; p++) begin
        restart(m);
        for (int t = 0; t < p; t++) begin
          do_tick();
          idle(4);
        end
        @(negedge clk) ext_low = 1'b1;
        @(negedge clk) ext_low = 1'b0;
        @(negedge clk);
        check("R4 not yet moved", int'(bp_index), p);
        @(negedge clk);
        check("R4 forced to last", int'(bp_index), m);
        check("R4 drive with force", int'(sync_drive_en), 1);
        idle(5);
        check("R4 stays last", int'(bp_index), m);
        do_tick();
        check("R4 wraps together", int'(bp_index), 0);
      end
    end

    // R5: line low while already in the final phase
    restart(2);
    do_tick(); do_tick();
    idle(3);
    @(negedge clk) ext_low = 1'b1;
    idle(4);
    ext_low = 1'b0;
    idle(4);
    check("R5 stays last", int'(bp_index), 2);
    do_tick();
    check("R5 tick wraps", int'(bp_index), 0);
    idle(5);
    check("R5 holds at zero", int'(bp_index), 0);

    // R7: realignment and tick on the same edge
    restart(3);
    @(negedge clk) ext_low = 1'b1;
    @(negedge clk) ext_low = 1'b0;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    check("R7 realign beats tick", int'(bp_index), 3);
    do_tick();
    check("R7 next tick wraps", int'(bp_index), 0);

    // R8: mode reduced below current index
    restart(3);
    do_tick(); do_tick(); do_tick();
    idle(4);
    check("R8 at phase three", int'(bp_index), 3);
    @(negedge clk) mux_mode = 2'd1;
    idle(4);
    check("R8 drive off out of range", int'(sync_drive_en), 0);
    check("R8 index held", int'(bp_index), 3);
    do_tick();
    check("R8 wraps to zero", int'(bp_index), 0);
    do_tick();
    check("R8 reaches new last", int'(bp_index), 1);
    check("R8 drive on new last", int'(sync_drive_en), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule